// File: doc/BRIEF.md
# Three-Axis Sample Queue with Selectable Overflow Policy

This block buffers acceleration samples, each a triple of 16-bit X, Y and Z values, between a sensor datapath and a consumer that drains them in bursts. A producer presents a triple with a one-cycle valid strobe. A consumer asks for data with a pop request, and the oldest stored triple appears on three output registers in the next cycle. All three axes always advance together, so a triple is never split.

A run-time mode input sets what happens to storage and to a full queue. In pass-through, nothing is stored and the output registers track the newest sample. In stop-on-full, the queue keeps its oldest contents and refuses new samples. In ring, the oldest triple is sacrificed for each new one. In armed ring, the queue behaves as a ring until a trigger pulse arrives, then holds like stop-on-full. The block reports a fill count and empty, full and threshold flags. Any mix of those flags can drive a single interrupt line, and a one-cycle overrun pulse marks every sample that was refused or that displaced an older one.

Top module: `triple_sample_fifo`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `level` is 0, `empty` is 1, `full` is 0, `overrun` is 0 and all three output registers are 0.
- R2: `mode` encodes 0 = pass-through, 1 = stop-on-full, 2 = ring, 3 = armed ring; the mode is sampled every cycle and changes take effect at once.
- R3: In pass-through, `level` is 0 from the cycle after the mode is seen (the stored contents are flushed), `pop` has no effect, and each strobed sample appears on the outputs one cycle later.
- R4: Outside pass-through, a strobed sample raises `level` by one in the next cycle, and a pop on a non-empty queue places the oldest stored triple on `out_x`/`out_y`/`out_z` in the next cycle and lowers `level` by one.
- R5: In stop-on-full, a sample strobed into a full queue without a pop is dropped, the contents are unchanged, and `overrun` is high for the next cycle.
- R6: In ring mode, a sample strobed into a full queue without a pop removes the oldest triple and is stored, `level` stays at the depth, and `overrun` is high for the next cycle.
- R7: In armed ring, the queue acts as ring mode until a cycle with `trig` high, and from the next cycle on acts as stop-on-full; leaving mode 3 disarms the trigger.
- R8: In stop-on-full, a push together with a pop on a full queue stores the new sample, returns the oldest, keeps `level` at the depth and raises no overrun.
- R9: A pop on an empty queue changes neither the output registers nor `level`.
- R10: `wm_flag` is high exactly when the mode is not pass-through and `level` is greater than or equal to `wm_level`.
- R11: `empty` is high when `level` is 0 and `full` is high when `level` equals the depth (32 by default); `level` never exceeds the depth.
- R12: `irq` is high when any enabled event is active: `irq_en` bit 0 enables empty, bit 1 enables full, bit 2 enables the threshold flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe for one cycle |
| in_x | input | 16 | X value of the incoming sample |
| in_y | input | 16 | Y value of the incoming sample |
| in_z | input | 16 | Z value of the incoming sample |
| pop | input | 1 | Request for the oldest stored triple |
| mode | input | 2 | Overflow and storage policy (see R2) |
| wm_level | input | 5 | Threshold for the fill flag |
| trig | input | 1 | Trigger pulse used in armed ring mode |
| irq_en | input | 3 | Interrupt enables: empty, full, threshold |
| out_x | output | 16 | X value of the last popped or passed sample |
| out_y | output | 16 | Y value of the last popped or passed sample |
| out_z | output | 16 | Z value of the last popped or passed sample |
| level | output | 6 | Number of stored triples |
| empty | output | 1 | Queue holds no triple |
| full | output | 1 | Queue holds the depth in triples |
| wm_flag | output | 1 | Fill count at or above the threshold |
| overrun | output | 1 | Pulse after a refused or displacing sample |
| irq | output | 1 | Interrupt from the enabled events |

## Verification
The bench drives the queue past its depth in each storing mode. A design that mixed up the two overflow policies would keep the newest samples in stop-on-full or the oldest in ring mode, and the popped values would give it away. It issues a push and a pop together on a full stop-on-full queue, where a design that checks fullness before honouring the pop would drop the sample and pulse overrun. It fires the trigger in armed ring mode after the ring has already wrapped, so a design that ignored the trigger, or that froze before wrapping, would show wrong data. It also pops an empty queue and switches to pass-through with data still stored, where stale output values or a nonzero count would expose a missing flush or an unguarded read pointer.

// File: rtl/fifo3_pkg.sv
package fifo3_pkg;

    localparam int AXES     = 3;
    localparam int SAMPLE_W = 16;

    typedef logic [SAMPLE_W-1:0] axis_t;
    // Index 0 = X, 1 = Y, 2 = Z.
    typedef axis_t [AXES-1:0] triple_t;

    typedef enum logic [1:0] {
        FM_PASS   = 2'd0,
        FM_STOP   = 2'd1,
        FM_RING   = 2'd2,
        FM_ARMED  = 2'd3
    } fmode_e;

    typedef struct packed {
        logic wm;
        logic full;
        logic empty;
    } evt_t;

    function automatic triple_t make_triple(input axis_t x, input axis_t y, input axis_t z);
        triple_t t;
        t[0] = x;
        t[1] = y;
        t[2] = z;
        return t;
    endfunction

endpackage

// File: rtl/fifo3_store.sv
module fifo3_store
    import fifo3_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  triple_t       wr_data,
    input  logic [AW-1:0] rd_addr,
    output triple_t       rd_data
);

    // One bank per axis; all banks share the pointers so a triple stays whole.
    for (genvar a = 0; a < AXES; a++) begin : g_bank
        axis_t bank [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en) begin
                bank[wr_addr] <= wr_data[a];
            end
        end

        assign rd_data[a] = bank[rd_addr];
    end

endmodule

// File: rtl/fifo3_ctrl.sv
module fifo3_ctrl
    import fifo3_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          pop,
    input  fmode_e        mode,
    input  logic          trig,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          load_pop,
    output logic          load_pass,
    output logic [LW-1:0] level,
    output logic          overrun
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic [AW-1:0] wp_q, rp_q;
    logic [LW-1:0] lvl_q;
    logic          armed_hit_q;
    logic          ovr_q;

    logic is_pass, hold_mode, is_full, is_empty;
    logic do_pop, do_push, displace, refuse, adv_rd;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        is_pass   = (mode == FM_PASS);
        hold_mode = (mode == FM_STOP) || ((mode == FM_ARMED) && armed_hit_q);
        is_full   = (lvl_q == FULL_LVL);
        is_empty  = (lvl_q == '0);
        do_pop    = pop && !is_empty && !is_pass;
        displace  = in_valid && !is_pass && is_full && !do_pop && !hold_mode;
        refuse    = in_valid && !is_pass && is_full && !do_pop && hold_mode;
        do_push   = in_valid && !is_pass && !refuse;
        adv_rd    = do_pop || displace;
    end

    always_ff @(posedge clk) begin
        if (rst || is_pass) begin
            wp_q  <= '0;
            rp_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (do_push) begin
                wp_q <= step_ptr(wp_q);
            end
            if (adv_rd) begin
                rp_q <= step_ptr(rp_q);
            end
            case ({do_push, adv_rd})
                2'b10:   lvl_q <= lvl_q + LW'(1);
                2'b01:   lvl_q <= lvl_q - LW'(1);
                default: lvl_q <= lvl_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || (mode != FM_ARMED)) begin
            armed_hit_q <= 1'b0;
        end else if (trig) begin
            armed_hit_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q <= 1'b0;
        end else begin
            ovr_q <= displace || refuse;
        end
    end

    assign wr_en     = do_push;
    assign wr_addr   = wp_q;
    assign rd_addr   = rp_q;
    assign load_pop  = do_pop;
    assign load_pass = is_pass && in_valid;
    assign level     = lvl_q;
    assign overrun   = ovr_q;

endmodule

// File: rtl/fifo3_flags.sv
module fifo3_flags
    import fifo3_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LW    = $clog2(DEPTH + 1),
    parameter int WMW   = $clog2(DEPTH)
) (
    input  logic [LW-1:0]  level,
    input  logic           is_pass,
    input  logic [WMW-1:0] wm_level,
    input  evt_t           irq_en,
    output evt_t           events,
    output logic           irq
);

    always_comb begin
        events.empty = (level == '0);
        events.full  = (level == LW'(DEPTH));
        events.wm    = !is_pass && (level >= LW'(wm_level));
        irq          = |(events & irq_en);
    end

endmodule

// File: rtl/triple_sample_fifo.sv
module triple_sample_fifo
    import fifo3_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = $clog2(DEPTH + 1),
    parameter int WMW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [15:0]    in_x,
    input  logic [15:0]    in_y,
    input  logic [15:0]    in_z,
    input  logic           pop,
    input  logic [1:0]     mode,
    input  logic [WMW-1:0] wm_level,
    input  logic           trig,
    input  logic [2:0]     irq_en,
    output logic [15:0]    out_x,
    output logic [15:0]    out_y,
    output logic [15:0]    out_z,
    output logic [LW-1:0]  level,
    output logic           empty,
    output logic           full,
    output logic           wm_flag,
    output logic           overrun,
    output logic           irq
);

    fmode_e        mode_e;
    triple_t       in_t, rd_t, out_q;
    logic          wr_en, load_pop, load_pass;
    logic [AW-1:0] wr_addr, rd_addr;
    evt_t          events;

    assign mode_e = fmode_e'(mode);
    assign in_t   = make_triple(in_x, in_y, in_z);

    fifo3_ctrl #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .pop       (pop),
        .mode      (mode_e),
        .trig      (trig),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .load_pop  (load_pop),
        .load_pass (load_pass),
        .level     (level),
        .overrun   (overrun)
    );

    fifo3_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (in_t),
        .rd_addr (rd_addr),
        .rd_data (rd_t)
    );

    fifo3_flags #(.DEPTH(DEPTH), .LW(LW), .WMW(WMW)) u_flags (
        .level    (level),
        .is_pass  (mode_e == FM_PASS),
        .wm_level (wm_level),
        .irq_en   (evt_t'(irq_en)),
        .events   (events),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (load_pop) begin
            out_q <= rd_t;
        end else if (load_pass) begin
            out_q <= in_t;
        end
    end

    assign out_x   = out_q[0];
    assign out_y   = out_q[1];
    assign out_z   = out_q[2];
    assign empty   = events.empty;
    assign full    = events.full;
    assign wm_flag = events.wm;

endmodule

// File: rtl/fifo3_chk.sv
module fifo3_chk #(
    parameter int DEPTH = 32,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          pop,
    input logic [1:0]    mode,
    input logic [LW-1:0] level,
    input logic          full,
    input logic          empty,
    input logic          overrun,
    input logic [15:0]   out_x,
    input logic [15:0]   out_y,
    input logic [15:0]   out_z
);

    p_level_bound_r11: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));

    p_pass_flush_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0) |=> (level == '0));

    p_stop_refuse_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && full && in_valid && !pop) |=> (full && overrun));

    p_ring_displace_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && full && in_valid && !pop) |=> (full && overrun));

    p_full_swap_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && full && in_valid && pop) |=> (full && !overrun));

    p_empty_pop_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd0 && empty && pop && !in_valid)
            |=> ($stable(out_x) && $stable(out_y) && $stable(out_z) && empty));

    p_no_growth_r4: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd0 && !in_valid) |=> (level <= $past(level)));

endmodule

bind triple_sample_fifo fifo3_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .pop      (pop),
    .mode     (mode),
    .level    (level),
    .full     (full),
    .empty    (empty),
    .overrun  (overrun),
    .out_x    (out_x),
    .out_y    (out_y),
    .out_z    (out_z)
);

// File: tb/sim_triple_sample_fifo.sv
module sim_triple_sample_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_x = '0, in_y = '0, in_z = '0;
    logic        pop = 1'b0;
    logic [1:0]  mode = 2'd1;
    logic [4:0]  wm_level = 5'd4;
    logic        trig = 1'b0;
    logic [2:0]  irq_en = 3'b000;
    logic [15:0] out_x, out_y, out_z;
    logic [5:0]  level;
    logic        empty, full, wm_flag, overrun, irq;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string phase = "R1";
    logic [15:0] seq = 16'h0100;

    // Reference model state
    logic [47:0] q[$];
    logic [47:0] m_out = '0;
    bit          m_ovr = 0;
    bit          m_armed = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    triple_sample_fifo u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_x(in_x), .in_y(in_y), .in_z(in_z),
        .pop(pop), .mode(mode), .wm_level(wm_level), .trig(trig), .irq_en(irq_en),
        .out_x(out_x), .out_y(out_y), .out_z(out_z),
        .level(level), .empty(empty), .full(full), .wm_flag(wm_flag),
        .overrun(overrun), .irq(irq)
    );

    always @(posedge clk) begin
        bit hold, ov;
        if (rst) begin
            q.delete();
            m_out = '0; m_ovr = 0; m_armed = 0;
        end else if (mode == 2'd0) begin
            q.delete();
            if (in_valid) m_out = {in_z, in_y, in_x};
            m_ovr = 0; m_armed = 0;
        end else begin
            hold = (mode == 2'd1) || (mode == 2'd3 && m_armed);
            ov = 0;
            if (pop && q.size() > 0) m_out = q.pop_front();
            if (in_valid) begin
                if (q.size() < DEPTH) q.push_back({in_z, in_y, in_x});
                else if (hold) ov = 1;
                else begin
                    void'(q.pop_front());
                    q.push_back({in_z, in_y, in_x});
                    ov = 1;
                end
            end
            m_ovr = ov;
            if (mode == 2'd3) begin
                if (trig) m_armed = 1;
            end else begin
                m_armed = 0;
            end
        end
    end

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        int  sz;
        bit  e_empty, e_full, e_wm;
        sz      = q.size();
        e_empty = (sz == 0);
        e_full  = (sz == DEPTH);
        e_wm    = (mode != 2'd0) && (sz >= int'(wm_level));
        chk(phase, "outputs", {16'h0, out_z, out_y, out_x}, {16'h0, m_out});
        chk(phase, "level", 64'(level), 64'(sz));
        chk(phase, "empty R11", 64'(empty), 64'(e_empty));
        chk(phase, "full R11", 64'(full), 64'(e_full));
        chk(phase, "wm_flag R10", 64'(wm_flag), 64'(e_wm));
        chk(phase, "overrun", 64'(overrun), 64'(m_ovr));
        chk(phase, "irq R12", 64'(irq),
            64'((irq_en[0] & e_empty) | (irq_en[1] & e_full) | (irq_en[2] & e_wm)));
    endtask

    task automatic cyc(input bit v, input bit p);
        @(negedge clk);
        compare_all();
        trig     = 1'b0;
        in_valid = v;
        pop      = p;
        if (v) begin
            seq  = seq + 16'h0011;
            in_x = seq;
            in_y = seq ^ 16'h5a5a;
            in_z = ~seq;
        end
    endtask

    task automatic run(input int n, input bit v, input bit p);
        for (int i = 0; i < n; i++) cyc(v, p);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        compare_all();
        chk("R1", "level in reset", 64'(level), 64'd0);
        chk("R1", "empty in reset", 64'(empty), 64'd1);
        rst = 1'b0;
        cyc(0, 0);
        chk("R1", "outputs after reset", {16'h0, out_z, out_y, out_x}, 64'd0);

        // R4: basic store and retrieve in stop-on-full mode
        phase = "R4"; mode = 2'd1; irq_en = 3'b100;
        run(5, 1, 0);
        run(3, 0, 1);
        for (int i = 0; i < 6; i++) cyc(i[0], !i[0]);
        cyc(1, 1);

        // R9: drain and pop past empty
        phase = "R9";
        run(6, 0, 1);
        run(3, 0, 1);
        cyc(0, 0);
        chk("R9", "level after extra pops", 64'(level), 64'd0);

        // R5: overfill stop-on-full
        phase = "R5"; irq_en = 3'b010; wm_level = 5'd31;
        run(DEPTH + 3, 1, 0);
        cyc(0, 0);
        chk("R11", "full after overfill", 64'(full), 64'd1);

        // R8: push and pop together while full
        phase = "R8";
        run(4, 1, 1);
        cyc(0, 0);
        chk("R8", "level stays at depth", 64'(level), 64'(DEPTH));

        // R3: pass-through flushes and tracks input
        phase = "R3"; mode = 2'd0; irq_en = 3'b111;
        run(3, 1, 1);
        run(2, 0, 1);
        cyc(0, 0);
        chk("R3", "flushed level", 64'(level), 64'd0);

        // R6: ring mode overfill then drain
        phase = "R6"; mode = 2'd2; wm_level = 5'd10; irq_en = 3'b101;
        run(DEPTH + 8, 1, 0);
        cyc(0, 0);
        chk("R2", "ring keeps depth", 64'(level), 64'(DEPTH));
        run(5, 0, 1);
        run(3, 1, 1);

        // R7: armed ring, trigger after wrap
        phase = "R7"; mode = 2'd1;
        run(DEPTH + 2, 0, 1);
        mode = 2'd3;
        run(DEPTH + 5, 1, 0);
        @(negedge clk);
        compare_all();
        trig = 1'b1; in_valid = 1'b1; pop = 1'b0;
        seq = seq + 16'h0011; in_x = seq; in_y = seq ^ 16'h5a5a; in_z = ~seq;
        run(4, 1, 0);
        run(DEPTH + 2, 0, 1);
        cyc(0, 0);
        chk("R7", "drained after trigger", 64'(level), 64'd0);

        // R10 / R12: threshold sweep with enables
        phase = "R10"; mode = 2'd2; wm_level = 5'd0;
        run(3, 1, 0);
        for (int w = 0; w < 8; w++) begin
            @(negedge clk);
            compare_all();
            wm_level = 5'(w);
            in_valid = 1'b0; pop = 1'b0;
        end
        phase = "R12";
        for (int e = 0; e < 8; e++) begin
            @(negedge clk);
            compare_all();
            irq_en = 3'(e);
        end
        run(3, 0, 1);
        run(2, 0, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule